// File: doc/BRIEF.md
# Threshold Offset Byte Loader

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Each offset is 12 bits wide and is held as two byte slots, a low byte and a high byte. Together they form four byte slots. Software loads them one byte at a time through the data input. A rotating slot pointer picks which byte each load lands in. A second rotating pointer, on the read clock, returns the same slots one at a time on the byte output.

Loading and read-back only take place when the FIFO is set to programmable-flag mode and the load strobe is held low. In the other mode, where the load pin acts as a second write enable, the block ignores all of that traffic. Each pointer keeps its position when the load strobe goes high. A later session therefore resumes at the slot after the last one it touched. The two combined 12-bit offsets go straight to the flag comparators.

Top module: `ofs_load_seq`

## Requirements
- R1: While reset is high, both offsets return to their defaults (7 by default) and `rd_byte` clears to zero. Both slot pointers return to slot 0.
- R2: Slot encoding: slot 0 is empty-offset bits 7:0, slot 1 is empty-offset bits 11:8, slot 2 is full-offset bits 7:0, and slot 3 is full-offset bits 11:8. A load happens on a rising `wr_clk` when `flag_mode`=1, `load_n`=0 and `wr_en_n`=0. It stores `din` into the current write slot, using only `din[3:0]` for slots 1 and 3. The write pointer then advances by one, and the new offset value shows on the outputs after that edge.
- R3: A load at slot 3 wraps the write pointer to slot 0, so the fifth load in a row lands in slot 0 again.
- R4: A `wr_clk` edge with `load_n`=1 or `wr_en_n`=1 changes neither offset nor the write pointer. The next load continues at the slot after the last one written.
- R5: A read-back happens on a rising `rd_clk` when `flag_mode`=1, `load_n`=0, `rd_en1_n`=0 and `rd_en2_n`=0. It places the current read slot on `rd_byte`, with bits 7:4 at zero for slots 1 and 3. The read pointer then advances and wraps after slot 3.
- R6: A `rd_clk` edge with either read enable high, or with `load_n`=1, leaves `rd_byte` and the read pointer unchanged.
- R7: With `flag_mode`=0, loads and read-backs are ignored. Offsets, `rd_byte` and both pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| flag_mode | input | 1 | 1 = programmable-flag mode, 0 = two-write-enable mode |
| load_n | input | 1 | Active-low offset access strobe |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en1_n | input | 1 | Active-low read enable, first |
| rd_en2_n | input | 1 | Active-low read enable, second |
| din | input | 8 | Byte to load |
| rd_byte | output | 8 | Read-back output register |
| empty_off | output | 12 | Almost-empty offset to flag logic |
| full_off | output | 12 | Almost-full offset to flag logic |

## Verification
The bench targets the pointer wrap, the resume after a partial session, the masking of the high nibble, and the ignore paths: a single disabled enable, and the other mode. A design whose pointer reset at each session would reload slot 0 when slot 1 or slot 2 was due. An off-by-one wrap would place the fifth byte in the full-offset high slot. Unmasked high bytes would push nonzero upper bits onto `rd_byte`. The closing sweep loads 256 distinct bytes with the two pointers out of phase. A mid-run reset then has to bring both offsets back to 7 and restart loading at slot 0.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    parameter int unsigned BYTE_W = 8;
    parameter int unsigned OFS_W  = 12;
    localparam int unsigned HI_W  = OFS_W - BYTE_W;

    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;

    typedef struct packed {
        logic [OFS_W-1:0] full;
        logic [OFS_W-1:0] empty;
    } ofs_t;

    function automatic slot_e next_slot(slot_e s);
        return slot_e'(s + 2'd1);
    endfunction

    function automatic logic is_hi_slot(slot_e s);
        return (s == SLOT_E_HI) || (s == SLOT_F_HI);
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(ofs_t o, slot_e s);
        case (s)
            SLOT_E_LO: return o.empty[BYTE_W-1:0];
            SLOT_E_HI: return BYTE_W'(o.empty[OFS_W-1:BYTE_W]);
            SLOT_F_LO: return o.full[BYTE_W-1:0];
            SLOT_F_HI: return BYTE_W'(o.full[OFS_W-1:BYTE_W]);
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/ofs_slot_ptr.sv
module ofs_slot_ptr
    import ofs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output slot_e slot
);
    always_ff @(posedge clk) begin
        if (rst)       slot <= SLOT_E_LO;
        else if (step) slot <= next_slot(slot);
    end

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step && slot == SLOT_F_HI) |=> (slot == SLOT_E_LO));

    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(slot));
endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
    import ofs_pkg::*;
#(
    parameter int unsigned DEF_EMPTY = 7,
    parameter int unsigned DEF_FULL  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  slot_e             slot,
    input  logic [BYTE_W-1:0] din,
    output ofs_t              ofs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ofs.empty <= OFS_W'(DEF_EMPTY);
            ofs.full  <= OFS_W'(DEF_FULL);
        end else if (we) begin
            case (slot)
                SLOT_E_LO: ofs.empty[BYTE_W-1:0]     <= din;
                SLOT_E_HI: ofs.empty[OFS_W-1:BYTE_W] <= din[HI_W-1:0];
                SLOT_F_LO: ofs.full[BYTE_W-1:0]      <= din;
                SLOT_F_HI: ofs.full[OFS_W-1:BYTE_W]  <= din[HI_W-1:0];
                default: ;
            endcase
        end
    end

    p_ofs_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ofs));

    p_hi_load_r2: assert property (@(posedge clk) disable iff (rst)
        (we && slot == SLOT_E_HI) |=> (ofs.empty[OFS_W-1:BYTE_W] == $past(din[HI_W-1:0])));
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import ofs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  ofs_t              ofs,
    output logic [BYTE_W-1:0] rd_byte
);
    slot_e rslot;

    ofs_slot_ptr u_rptr (
        .clk  (clk),
        .rst  (rst),
        .step (re),
        .slot (rslot)
    );

    always_ff @(posedge clk) begin
        if (rst)     rd_byte <= '0;
        else if (re) rd_byte <= pick_byte(ofs, rslot);
    end

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rd_byte));

    p_rd_hi_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (re && is_hi_slot(rslot)) |=> (rd_byte[BYTE_W-1:HI_W] == '0));
endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
    import ofs_pkg::*;
#(
    parameter int unsigned DEF_EMPTY = 7,
    parameter int unsigned DEF_FULL  = 7
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              flag_mode,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [OFS_W-1:0]  empty_off,
    output logic [OFS_W-1:0]  full_off
);
    logic  wr_fire;
    logic  rd_fire;
    slot_e wslot;
    ofs_t  ofs;

    assign wr_fire = flag_mode && !load_n && !wr_en_n;
    assign rd_fire = flag_mode && !load_n && !rd_en1_n && !rd_en2_n;

    ofs_slot_ptr u_wptr (
        .clk  (wr_clk),
        .rst  (wr_rst),
        .step (wr_fire),
        .slot (wslot)
    );

    ofs_regfile #(
        .DEF_EMPTY (DEF_EMPTY),
        .DEF_FULL  (DEF_FULL)
    ) u_regs (
        .clk  (wr_clk),
        .rst  (wr_rst),
        .we   (wr_fire),
        .slot (wslot),
        .din  (din),
        .ofs  (ofs)
    );

    ofs_readback u_rb (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .re      (rd_fire),
        .ofs     (ofs),
        .rd_byte (rd_byte)
    );

    assign empty_off = ofs.empty;
    assign full_off  = ofs.full;

    p_mode_ignore_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !flag_mode |=> ($stable(empty_off) && $stable(full_off)));
endmodule

// File: tb/tb_ofs_load_seq.sv
module tb_ofs_load_seq;
    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst = 1'b1;
    logic       flag_mode = 1'b1;
    logic       load_n = 1'b1;
    logic       wr_en_n = 1'b1;
    logic       rd_en1_n = 1'b1;
    logic       rd_en2_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] rd_byte;
    logic [11:0] empty_off, full_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] m_e, m_f;
    logic [7:0]  m_rd;
    int          m_wp, m_rp;

    always #2 wr_clk = ~wr_clk;
    initial begin
        #1;
        forever #2 rd_clk = ~rd_clk;
    end

    ofs_load_seq dut (
        .wr_clk(wr_clk), .wr_rst(rst), .rd_clk(rd_clk), .rd_rst(rst),
        .flag_mode(flag_mode), .load_n(load_n), .wr_en_n(wr_en_n),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .din(din),
        .rd_byte(rd_byte), .empty_off(empty_off), .full_off(full_off)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte(int s);
        case (s)
            0: return m_e[7:0];
            1: return {4'h0, m_e[11:8]};
            2: return m_f[7:0];
            default: return {4'h0, m_f[11:8]};
        endcase
    endfunction

    task automatic check_ofs(input string req);
        check(empty_off == m_e, {req, " empty_off"}, empty_off, m_e);
        check(full_off == m_f, {req, " full_off"}, full_off, m_f);
    endtask

    task automatic do_load(input logic [7:0] d, input logic mode, input logic ld, input logic wen, input string req);
        @(negedge wr_clk);
        flag_mode = mode; load_n = ld; wr_en_n = wen; din = d;
        @(posedge wr_clk);
        if (mode && !ld && !wen) begin
            case (m_wp)
                0: m_e[7:0]  = d;
                1: m_e[11:8] = d[3:0];
                2: m_f[7:0]  = d;
                default: m_f[11:8] = d[3:0];
            endcase
            m_wp = (m_wp + 1) % 4;
        end
        @(negedge wr_clk);
        load_n = 1'b1; wr_en_n = 1'b1; flag_mode = 1'b1;
        check_ofs(req);
    endtask

    task automatic do_read(input logic mode, input logic ld, input logic r1, input logic r2, input string req);
        @(negedge rd_clk);
        flag_mode = mode; load_n = ld; rd_en1_n = r1; rd_en2_n = r2;
        @(posedge rd_clk);
        if (mode && !ld && !r1 && !r2) begin
            m_rd = model_byte(m_rp);
            m_rp = (m_rp + 1) % 4;
        end
        @(negedge rd_clk);
        load_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1; flag_mode = 1'b1;
        check(rd_byte == m_rd, {req, " rd_byte"}, rd_byte, m_rd);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge wr_clk);
        @(negedge wr_clk);
        rst = 1'b0;
        m_e = 12'd7; m_f = 12'd7; m_rd = 8'h00; m_wp = 0; m_rp = 0;
        @(negedge rd_clk);
    endtask

    initial begin
        do_reset();
        // R1 defaults
        check_ofs("R1");
        check(rd_byte == 8'h00, "R1 rd_byte", rd_byte, 0);
        // R1/R5 read pointer starts at slot 0
        for (int i = 0; i < 4; i++) do_read(1, 0, 0, 0, "R1 R5 default readback");
        // R2 one load per slot
        do_load(8'hA5, 1, 0, 0, "R2 slot0");
        do_load(8'h3C, 1, 0, 0, "R2 slot1");
        do_load(8'h5A, 1, 0, 0, "R2 slot2");
        do_load(8'hC9, 1, 0, 0, "R2 slot3");
        check(empty_off == 12'hCA5, "R2 empty value", empty_off, 12'hCA5);
        check(full_off == 12'h95A, "R2 full value", full_off, 12'h95A);
        // R5 read-back with high nibble masking
        for (int i = 0; i < 4; i++) do_read(1, 0, 0, 0, "R5 readback");
        // R3 fifth load wraps to slot 0
        do_load(8'h11, 1, 0, 0, "R3 wrap");
        check(empty_off[7:0] == 8'h11, "R3 slot0 again", empty_off[7:0], 8'h11);
        // R4 disabled loads ignored; pointer resumes
        do_load(8'hEE, 1, 1, 0, "R4 load_n high");
        do_load(8'hDD, 1, 0, 1, "R4 wr_en_n high");
        do_load(8'h22, 1, 0, 0, "R4 resume slot1");
        check(empty_off == 12'h211, "R4 resume value", empty_off, 12'h211);
        // R6 disabled reads hold
        do_read(1, 0, 1, 0, "R6 rd_en1_n high");
        do_read(1, 0, 0, 1, "R6 rd_en2_n high");
        do_read(1, 1, 0, 0, "R6 load_n high");
        do_read(1, 0, 0, 0, "R6 resume slot0");
        // R7 other mode ignores everything
        do_load(8'hFF, 0, 0, 0, "R7 load ignored");
        do_read(0, 0, 0, 0, "R7 read ignored");
        do_load(8'h44, 1, 0, 0, "R7 wptr held slot2");
        check(full_off[7:0] == 8'h44, "R7 slot2 value", full_off[7:0], 8'h44);
        do_read(1, 0, 0, 0, "R7 rptr held slot1");
        // R2 R3 R5 sweep over all byte values, pointers out of phase
        for (int g = 0; g < 64; g++) begin
            for (int k = 0; k < 4; k++) do_load(8'((g * 4 + k) * 37 + 5), 1, 0, 0, "R2 R3 sweep load");
            for (int k = 0; k < 4; k++) do_read(1, 0, 0, 0, "R5 sweep read");
        end
        // R1 mid-run reset
        do_reset();
        check_ofs("R1 rereset");
        check(rd_byte == 8'h00, "R1 rereset rd_byte", rd_byte, 0);
        do_load(8'h33, 1, 0, 0, "R1 wptr back to slot0");
        check(empty_off == 12'h033, "R1 slot0 after reset", empty_off, 12'h033);
        do_read(1, 0, 0, 0, "R1 rptr back to slot0");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule